// File: doc/BRIEF.md
# Raster Line Timing and Pixel Priority Unit

This unit runs the horizontal and vertical timing of a tile-and-sprite display engine, one scanline at a time. A line lasts a fixed number of master clocks and a frame a fixed number of lines. From programmed start and length values it derives which lines and which dots are visible. For each visible dot it merges one background pixel and one sprite pixel into a 9-bit palette index. It also produces a raster-match interrupt, a vertical-blank interrupt and a start pulse for the sprite-attribute-table DMA.

Tile and sprite fetch happen upstream. They present colour, palette and priority for the current dot on the pixel inputs. The palette index goes downstream to a colour lookup. A divider input sets how many master clocks each dot lasts.

Top module: `raster_line_gen`

## Requirements
- R1: The unit counts `LINE_CLKS` (default 1365) master clocks per line, numbered 0 to `LINE_CLKS`-1. It counts `FRAME_LINES` (default 262) lines per frame, and the line number wraps to 0 after the last line.
- R2: The vertical window is sampled on the first clock of line 0 and held for the frame. The first visible line is max(2, `vstart_i`) − 2. The window height is min(`VMAX` (default 242), `vlen_i` + 1) lines. A line is visible when its number is at least the first visible line and the visible-line offset is below the height.
- R3: On the first clock of every line, the dot start is sampled from `hstart_i` and the dot count from (`hlen_i` + 1) × 8. Both are held for the rest of the line.
- R4: A dot begins on a clock where all of these hold: the line is visible, the in-line clock is at least the dot start, the in-line clock is below `ACT_LIMIT` (default 1360), fewer dots than the dot count have begun on this line, and the previous dot has finished. `pix_stb_o` is high for the single cycle after a dot begins. Any unfinished dot is cut off at the end of the line.
- R5: Dot selection: a non-zero sprite colour with `spr_pri_i` set wins. Otherwise a non-zero background colour wins. Otherwise a non-zero sprite colour is used. Otherwise the result is 0.
- R6: `pix_o` bit 8 is 1 when a sprite was chosen, bits 7:4 carry the chosen palette and bits 3:0 the chosen colour. The value appears the cycle after the dot begins and is held for the dot's length. Outside dots `pix_o` is 0.
- R7: On the last clock of a visible line, if the visible-line offset equals `raster_i` − 64 and `line_irq_en_i` is high, `line_irq_o` pulses for one cycle on the next cycle. The offset is 0 at line 0 and advances by one after each visible line.
- R8: On the last clock of the line whose number equals first visible line plus window height, `vblank_irq_o` pulses for one cycle on the next cycle, provided `vblank_irq_en_i` is high.
- R9: `sat_dma_o` pulses in the same cycle as the R8 event, whatever the state of `vblank_irq_en_i`.
- R10: While `rst_ni` is low, all outputs are 0 and the counters restart at line 0, clock 0.
- R11: `dot_div_i` is sampled when a dot begins and sets the dot's length in master clocks. A value of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vstart_i | input | 8 | Vertical display start value |
| vlen_i | input | 9 | Vertical display length value |
| hstart_i | input | 8 | Horizontal dot start, in master clocks |
| hlen_i | input | 6 | Horizontal length, in groups of 8 dots minus one |
| raster_i | input | 10 | Raster-compare value, biased by 64 |
| dot_div_i | input | 3 | Master clocks per dot |
| line_irq_en_i | input | 1 | Raster-match interrupt enable |
| vblank_irq_en_i | input | 1 | Vertical-blank interrupt enable |
| bg_col_i | input | 4 | Background colour of current dot |
| bg_pal_i | input | 4 | Background palette of current dot |
| spr_col_i | input | 4 | Sprite colour of current dot |
| spr_pal_i | input | 4 | Sprite palette of current dot |
| spr_pri_i | input | 1 | Sprite over-background priority |
| pix_o | output | 9 | Sprite flag, palette and colour |
| pix_stb_o | output | 1 | A new dot started on the previous edge |
| line_irq_o | output | 1 | Raster-match interrupt pulse |
| vblank_irq_o | output | 1 | Vertical-blank interrupt pulse |
| sat_dma_o | output | 1 | Sprite-table DMA start pulse |

## Verification
Every output is a register. Each result therefore appears exactly one cycle after the clock edge on which its condition holds: the first clock of a dot for `pix_o` and `pix_stb_o`, and the last clock of a line for the interrupts and the DMA pulse. The bench model takes one step on every rising edge, using the same input values the design samples, to produce the outputs due in the next cycle. It compares them with the design at the following falling edge. Register values change at scattered points within lines and frames, so the sampling points of R2, R3, R7 and R11 are exercised: a change is seen only at the boundary where it is due.

// File: rtl/raster_line_gen_pkg.sv
package raster_line_gen_pkg;

  typedef struct packed {
    logic       spr;
    logic [3:0] pal;
    logic [3:0] col;
  } pix_t;

  function automatic pix_t pick_pixel(logic [3:0] bg_col, logic [3:0] bg_pal,
                                      logic [3:0] sp_col, logic [3:0] sp_pal,
                                      logic sp_pri);
    pix_t p;
    p = '0;
    if (sp_col != 4'd0 && sp_pri)  p = '{spr: 1'b1, pal: sp_pal, col: sp_col};
    else if (bg_col != 4'd0)       p = '{spr: 1'b0, pal: bg_pal, col: bg_col};
    else if (sp_col != 4'd0)       p = '{spr: 1'b1, pal: sp_pal, col: sp_col};
    return p;
  endfunction

endpackage

// File: rtl/rlg_counters.sv
module rlg_counters #(
  parameter int LINE_CLKS   = 1365,
  parameter int FRAME_LINES = 262,
  parameter int HW          = 11,
  parameter int VW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic          line_first_o,
  output logic          line_last_o,
  output logic          frame_first_o,
  output logic          frame_end_o
);
  logic [HW-1:0] hcnt_q;
  logic [VW-1:0] vcnt_q;
  logic          last_line;

  assign line_last_o   = hcnt_q == HW'(LINE_CLKS - 1);
  assign line_first_o  = hcnt_q == '0;
  assign last_line     = vcnt_q == VW'(FRAME_LINES - 1);
  assign frame_first_o = line_first_o && vcnt_q == '0;
  assign frame_end_o   = line_last_o && last_line;
  assign hcnt_o        = hcnt_q;
  assign vcnt_o        = vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (line_last_o) begin
      hcnt_q <= '0;
      vcnt_q <= last_line ? '0 : vcnt_q + VW'(1);
    end else begin
      hcnt_q <= hcnt_q + HW'(1);
    end
  end
endmodule

// File: rtl/rlg_vwin.sv
module rlg_vwin #(
  parameter int VMAX = 242,
  parameter int VOFS = 2,
  parameter int BIAS = 64,
  parameter int VS_W = 8,
  parameter int VL_W = 9,
  parameter int VX_W = 11,
  parameter int VW   = 9,
  parameter int RC_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VW-1:0]   vcnt_i,
  input  logic            frame_first_i,
  input  logic            line_last_i,
  input  logic            frame_end_i,
  input  logic [VS_W-1:0] vstart_i,
  input  logic [VL_W-1:0] vlen_i,
  input  logic [RC_W-1:0] raster_i,
  input  logic            line_irq_en_i,
  input  logic            vblank_irq_en_i,
  output logic            line_act_o,
  output logic            line_irq_o,
  output logic            vblank_irq_o,
  output logic            sat_dma_o
);
  logic [VX_W-1:0] vs_live, vl_live, vl_inc, vs_q, vl_q, vs_e, vl_e;
  logic [VX_W-1:0] voff_q, vcnt_x, vend;
  logic [RC_W-1:0] rc_tgt;

  always_comb begin
    vs_live = (VX_W'(vstart_i) < VX_W'(VOFS)) ? '0 : VX_W'(vstart_i) - VX_W'(VOFS);
    vl_inc  = VX_W'(vlen_i) + VX_W'(1);
    vl_live = (vl_inc > VX_W'(VMAX)) ? VX_W'(VMAX) : vl_inc;
    // window values become live on the frame's first clock
    vs_e    = frame_first_i ? vs_live : vs_q;
    vl_e    = frame_first_i ? vl_live : vl_q;
    vcnt_x  = VX_W'(vcnt_i);
    vend    = vs_q + vl_q;
    rc_tgt  = raster_i - RC_W'(BIAS);
  end

  assign line_act_o = (vcnt_x >= vs_e) && (voff_q < vl_e);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q         <= '0;
      vl_q         <= '0;
      voff_q       <= '0;
      line_irq_o   <= 1'b0;
      vblank_irq_o <= 1'b0;
      sat_dma_o    <= 1'b0;
    end else begin
      line_irq_o   <= 1'b0;
      vblank_irq_o <= 1'b0;
      sat_dma_o    <= 1'b0;
      if (frame_first_i) begin
        vs_q <= vs_live;
        vl_q <= vl_live;
      end
      if (line_last_i) begin
        if (line_act_o) begin
          line_irq_o <= line_irq_en_i && (VX_W'(rc_tgt) == voff_q);
          voff_q     <= voff_q + VX_W'(1);
        end
        if (vcnt_x == vend) begin
          vblank_irq_o <= vblank_irq_en_i;
          sat_dma_o    <= 1'b1;
        end
        if (frame_end_i) voff_q <= '0;
      end
    end
  end
endmodule

// File: rtl/rlg_pixel.sv
module rlg_pixel
  import raster_line_gen_pkg::*;
#(
  parameter int HW        = 11,
  parameter int HS_W      = 8,
  parameter int HL_W      = 6,
  parameter int DIV_W     = 3,
  parameter int ACT_LIMIT = 1360
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HW-1:0]    hcnt_i,
  input  logic             line_first_i,
  input  logic             line_last_i,
  input  logic             line_act_i,
  input  logic [HS_W-1:0]  hstart_i,
  input  logic [HL_W-1:0]  hlen_i,
  input  logic [DIV_W-1:0] dot_div_i,
  input  logic [3:0]       bg_col_i,
  input  logic [3:0]       bg_pal_i,
  input  logic [3:0]       spr_col_i,
  input  logic [3:0]       spr_pal_i,
  input  logic             spr_pri_i,
  output pix_t             pix_o,
  output logic             pix_stb_o
);
  localparam int CNT_W = HL_W + 4;
  localparam int HC_W  = (HW > HS_W) ? HW : HS_W;

  logic [HS_W-1:0]  hs_q, hs_e;
  logic [CNT_W-1:0] hl_q, hl_e, hl_live, cnt_q;
  logic [DIV_W-1:0] rem_q, div_m1;
  logic             start;

  always_comb begin
    hl_live = (CNT_W'(hlen_i) + CNT_W'(1)) << 3;
    hs_e    = line_first_i ? hstart_i : hs_q;
    hl_e    = line_first_i ? hl_live : hl_q;
    div_m1  = (dot_div_i == '0) ? '0 : dot_div_i - DIV_W'(1);
    start   = line_act_i && (HC_W'(hcnt_i) >= HC_W'(hs_e)) &&
              (HC_W'(hcnt_i) < HC_W'(ACT_LIMIT)) && (cnt_q < hl_e) && (rem_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q      <= '0;
      hl_q      <= '0;
      cnt_q     <= '0;
      rem_q     <= '0;
      pix_o     <= '0;
      pix_stb_o <= 1'b0;
    end else begin
      if (line_first_i) begin
        hs_q <= hstart_i;
        hl_q <= hl_live;
      end
      pix_stb_o <= start;
      if (start) begin
        pix_o <= pick_pixel(bg_col_i, bg_pal_i, spr_col_i, spr_pal_i, spr_pri_i);
        rem_q <= div_m1;
        cnt_q <= cnt_q + CNT_W'(1);
      end else if (rem_q != '0) begin
        rem_q <= rem_q - DIV_W'(1);
      end else begin
        pix_o <= '0;
      end
      // a dot still running at line end is cut off
      if (line_last_i) begin
        cnt_q <= '0;
        rem_q <= '0;
      end
    end
  end
endmodule

// File: rtl/raster_line_gen.sv
module raster_line_gen
  import raster_line_gen_pkg::*;
#(
  parameter int LINE_CLKS   = 1365,
  parameter int FRAME_LINES = 262,
  parameter int ACT_LIMIT   = 1360,
  parameter int VMAX        = 242,
  parameter int VOFS        = 2,
  parameter int BIAS        = 64,
  parameter int VS_W        = 8,
  parameter int VL_W        = 9,
  parameter int HS_W        = 8,
  parameter int HL_W        = 6,
  parameter int RC_W        = 10,
  parameter int DIV_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VS_W-1:0]  vstart_i,
  input  logic [VL_W-1:0]  vlen_i,
  input  logic [HS_W-1:0]  hstart_i,
  input  logic [HL_W-1:0]  hlen_i,
  input  logic [RC_W-1:0]  raster_i,
  input  logic [DIV_W-1:0] dot_div_i,
  input  logic             line_irq_en_i,
  input  logic             vblank_irq_en_i,
  input  logic [3:0]       bg_col_i,
  input  logic [3:0]       bg_pal_i,
  input  logic [3:0]       spr_col_i,
  input  logic [3:0]       spr_pal_i,
  input  logic             spr_pri_i,
  output logic [8:0]       pix_o,
  output logic             pix_stb_o,
  output logic             line_irq_o,
  output logic             vblank_irq_o,
  output logic             sat_dma_o
);
  localparam int HW   = $clog2(LINE_CLKS);
  localparam int VW   = $clog2(FRAME_LINES);
  localparam int VX_W = VL_W + 2;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_first, line_last, frame_first, frame_end, line_act;
  pix_t          pix;

  rlg_counters #(
    .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .HW(HW), .VW(VW)
  ) u_cnt (
    .clk_i, .rst_ni,
    .hcnt_o(hcnt), .vcnt_o(vcnt),
    .line_first_o(line_first), .line_last_o(line_last),
    .frame_first_o(frame_first), .frame_end_o(frame_end)
  );

  rlg_vwin #(
    .VMAX(VMAX), .VOFS(VOFS), .BIAS(BIAS), .VS_W(VS_W), .VL_W(VL_W),
    .VX_W(VX_W), .VW(VW), .RC_W(RC_W)
  ) u_vwin (
    .clk_i, .rst_ni,
    .vcnt_i(vcnt), .frame_first_i(frame_first), .line_last_i(line_last),
    .frame_end_i(frame_end), .vstart_i, .vlen_i, .raster_i,
    .line_irq_en_i, .vblank_irq_en_i,
    .line_act_o(line_act), .line_irq_o, .vblank_irq_o, .sat_dma_o
  );

  rlg_pixel #(
    .HW(HW), .HS_W(HS_W), .HL_W(HL_W), .DIV_W(DIV_W), .ACT_LIMIT(ACT_LIMIT)
  ) u_pix (
    .clk_i, .rst_ni,
    .hcnt_i(hcnt), .line_first_i(line_first), .line_last_i(line_last),
    .line_act_i(line_act), .hstart_i, .hlen_i, .dot_div_i,
    .bg_col_i, .bg_pal_i, .spr_col_i, .spr_pal_i, .spr_pri_i,
    .pix_o(pix), .pix_stb_o
  );

  assign pix_o = pix;
endmodule

// File: rtl/raster_line_gen_chk.sv
module raster_line_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [8:0] pix_o,
  input logic       pix_stb_o,
  input logic       line_irq_o,
  input logic       vblank_irq_o,
  input logic       sat_dma_o,
  input logic       line_irq_en_i,
  input logic       vblank_irq_en_i,
  input logic [3:0] spr_col_i,
  input logic       spr_pri_i
);
  AST_LINE_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_irq_o |=> !line_irq_o);                                          // R7
  AST_LINE_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_irq_o |-> $past(line_irq_en_i));                                 // R7
  AST_VBLANK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_irq_o |-> $past(vblank_irq_en_i));                             // R8
  AST_VBLANK_WITH_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_irq_o |-> sat_dma_o);                                          // R9
  AST_DMA_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_dma_o |=> !sat_dma_o);                                            // R9
  AST_ZERO_COLOR_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_stb_o && pix_o[3:0] == 4'd0) |-> pix_o == 9'd0);                 // R6
  AST_SPRITE_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_stb_o && $past(spr_pri_i && spr_col_i != 4'd0)) |-> pix_o[8]);   // R5
  AST_HOLD_OR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_stb_o |-> (pix_o == 9'd0 || $stable(pix_o)));                    // R4
endmodule

bind raster_line_gen raster_line_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_o(pix_o), .pix_stb_o(pix_stb_o),
  .line_irq_o(line_irq_o), .vblank_irq_o(vblank_irq_o), .sat_dma_o(sat_dma_o),
  .line_irq_en_i(line_irq_en_i), .vblank_irq_en_i(vblank_irq_en_i),
  .spr_col_i(spr_col_i), .spr_pri_i(spr_pri_i)
);

// File: tb/raster_line_gen_bench.sv
module raster_line_gen_bench;
  localparam int LINE  = 100;
  localparam int FRAME = 24;
  localparam int LIMIT = 95;
  localparam int VMAX  = 16;
  localparam int RUN   = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] vstart;
  logic [8:0] vlen;
  logic [7:0] hstart;
  logic [5:0] hlen;
  logic [9:0] raster;
  logic [2:0] dot_div;
  logic       line_en, vb_en;
  logic [3:0] bg_col, bg_pal, spr_col, spr_pal;
  logic       spr_pri;
  logic [8:0] pix;
  logic       pix_stb, line_irq, vblank_irq, sat_dma;

  raster_line_gen #(
    .LINE_CLKS(LINE), .FRAME_LINES(FRAME), .ACT_LIMIT(LIMIT), .VMAX(VMAX)
  ) u_raster_line_gen (
    .clk_i(clk), .rst_ni(rst_n), .vstart_i(vstart), .vlen_i(vlen),
    .hstart_i(hstart), .hlen_i(hlen), .raster_i(raster), .dot_div_i(dot_div),
    .line_irq_en_i(line_en), .vblank_irq_en_i(vb_en),
    .bg_col_i(bg_col), .bg_pal_i(bg_pal), .spr_col_i(spr_col), .spr_pal_i(spr_pal),
    .spr_pri_i(spr_pri), .pix_o(pix), .pix_stb_o(pix_stb), .line_irq_o(line_irq),
    .vblank_irq_o(vblank_irq), .sat_dma_o(sat_dma)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_h = 0, m_v = 0, m_voff = 0, m_vs = 0, m_vl = 0, m_hs = 0, m_hl = 0;
  int m_cnt = 0, m_rem = 0;
  int e_pix = 0, e_stb = 0, e_li = 0, e_vb = 0, e_dma = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int sel_dot(int bc, int bp, int sc, int sp, int pri);
    if (sc != 0 && pri != 0) return 256 + sp * 16 + sc;
    if (bc != 0) return bp * 16 + bc;
    if (sc != 0) return 256 + sp * 16 + sc;
    return 0;
  endfunction

  task automatic model_step();
    bit act, start;
    int dv;
    if (m_h == 0) begin
      m_hs = int'(hstart);
      m_hl = (int'(hlen) + 1) * 8;
      if (m_v == 0) begin
        m_vs = (int'(vstart) < 2) ? 0 : int'(vstart) - 2;
        m_vl = (int'(vlen) + 1 > VMAX) ? VMAX : int'(vlen) + 1;
      end
    end
    act   = (m_v >= m_vs) && (m_voff < m_vl);
    start = act && m_h >= m_hs && m_h < LIMIT && m_cnt < m_hl && m_rem == 0;
    e_stb = start; e_li = 0; e_vb = 0; e_dma = 0;
    if (start) begin
      e_pix = sel_dot(int'(bg_col), int'(bg_pal), int'(spr_col), int'(spr_pal), int'(spr_pri));
      dv    = (dot_div == 3'd0) ? 1 : int'(dot_div);
      m_rem = dv - 1;
      m_cnt++;
    end else if (m_rem > 0) begin
      m_rem--;
    end else begin
      e_pix = 0;
    end
    if (m_h == LINE - 1) begin
      if (act) begin
        if (m_voff == int'(raster) - 64 && line_en) e_li = 1;
        m_voff++;
      end
      if (m_v == m_vs + m_vl) begin
        e_vb  = vb_en;
        e_dma = 1;
      end
      m_h = 0; m_cnt = 0; m_rem = 0;
      if (m_v == FRAME - 1) begin m_v = 0; m_voff = 0; end
      else m_v++;
    end else begin
      m_h++;
    end
  endtask

  task automatic drive(int c);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    bg_col  = lf[3:0] & {4{lf[8]}};
    spr_col = lf[7:4] & {4{lf[9]}};
    bg_pal  = lf[11:8];
    spr_pal = lf[15:12];
    spr_pri = lf[14];
    case (c)
      1200: begin vstart = 8'd0; vlen = 9'd40; hstart = 8'd70; hlen = 6'd3;
                  dot_div = 3'd1; raster = 10'd79; line_en = 1'b0; end
      2650: line_en = 1'b1;
      3000: raster = 10'd10;
      3650: raster = 10'd79;
      4000: begin vstart = 8'd20; vlen = 9'd2; hstart = 8'd0; hlen = 6'd0; dot_div = 3'd0; end
      5050: dot_div = 3'd3;
      6900: vb_en = 1'b0;
      7300: begin vstart = 8'd22; vlen = 9'd9; vb_en = 1'b1; raster = 10'd65; end
      8420: begin hstart = 8'd10; hlen = 6'd9; dot_div = 3'd7; end
      default: ;
    endcase
  endtask

  task automatic run_main();
    for (int i = 0; i < RUN; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      check("R1 R2 R3 R4 R11 pix_stb_o", int'(pix_stb), e_stb);
      check("R5 R6 pix_o", int'(pix), e_pix);
      check("R7 line_irq_o", int'(line_irq), e_li);
      check("R8 vblank_irq_o", int'(vblank_irq), e_vb);
      check("R9 sat_dma_o", int'(sat_dma), e_dma);
      cyc++;
      drive(cyc);
    end
  endtask

  initial begin
    vstart = 8'd3; vlen = 9'd4; hstart = 8'd5; hlen = 6'd1; raster = 10'd66;
    dot_div = 3'd2; line_en = 1'b1; vb_en = 1'b1;
    bg_col = '0; bg_pal = '0; spr_col = '0; spr_pal = '0; spr_pri = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet under reset
    check("R10 pix_o", int'(pix), 0);
    check("R10 pix_stb_o", int'(pix_stb), 0);
    check("R10 line_irq_o", int'(line_irq), 0);
    check("R10 vblank_irq_o", int'(vblank_irq), 0);
    check("R10 sat_dma_o", int'(sat_dma), 0);
    rst_n = 1'b1;
    fork
      run_main();
      begin
        repeat (RUN * 3) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, RUN);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule